// File: doc/BRIEF.md
# Bus-to-Memory Page Map Translator

This block sits between a 22-bit peripheral bus and main memory. Each bus address is split into a 13-bit page number (bits 21:9) and a 9-bit byte offset (bits 8:0). The page number selects one 32-bit entry of a translation table that is kept in main memory itself, at a 32 KB-aligned base supplied on `map_base`. The block fetches that entry through its memory port, checks that the entry is valid, and builds the physical address. It then performs the requested read, or a byte, word or longword write, on the translated location. Byte and word writes are done as a read-modify-write of the containing longword.

A translation can fail at three points. The entry address can lie outside installed memory, which is a slave error at page 0. The entry can be marked invalid, which is a master error that carries the bus page. The translated address can lie outside installed memory, which is a slave error that carries the physical page. Each of these raises a one-cycle error event with its page and an error flag in the response. A failed read also raises a machine-check flag.

A console mode runs the same lookup without touching any error state. It returns the physical address with no range check and makes no access to the data itself. The block serves one request at a time. Installed memory size is a parameter: an address counts as present when it is below that size.

Top module: `busmap_xlate`

## Requirements
- R1: During and after reset `req_ready` is 1, and `rsp_valid`, `rsp_err`, `rsp_mcheck`, `merr_evt`, `serr_evt`, `mem_rd_en` and `mem_wr_en` are all 0.
- R2: The entry is fetched from the byte address `{map_base[29:15], req_addr[21:9], 2'b00}`. Bits 14:0 of `map_base` have no effect on any result.
- R3: If the entry address is not below `MEM_BYTES`, the request fails with `rsp_err`=1 and `serr_evt`=1 with `serr_page`=0. No memory access is made.
- R4: An entry whose bit 31 is 0 fails the request with `rsp_err`=1 and `merr_evt`=1, and `merr_page` equals `req_addr[21:9]`.
- R5: The physical address is `{entry[19:0], req_addr[8:0]}`, and entry bits 30:20 are ignored. If it is not below `MEM_BYTES`, the request fails with `serr_evt`=1 and `serr_page`=`entry[19:0]`, and no data access is made.
- R6: A successful read returns in `rsp_rdata` the longword at the physical address with bits 1:0 cleared, and returns the physical address in `rsp_paddr`.
- R7: `req_size` 0 is a byte, 1 is a word, and 2 or 3 is a longword. A longword write stores `req_wdata` whole. A byte write replaces bits `8*a[1:0]+7 : 8*a[1:0]` with `req_wdata[7:0]`. A word write replaces bits `16*a[1]+15 : 16*a[1]` with `req_wdata[15:0]` (a[0] is ignored). All other bytes keep their old value. Exactly one memory write is made per successful write.
- R8: `rsp_mcheck` is 1 only for a failed non-console read. A failed write makes no memory write and leaves memory unchanged.
- R9: In console mode no error event and no machine check are raised, and no memory write is made. `rsp_paddr` returns the physical address even when it lies beyond `MEM_BYTES`. An invalid entry or an out-of-range entry address still gives `rsp_err`=1.
- R10: A request is accepted only while `req_ready` is 1, and `req_ready` is 0 from acceptance until the response. `rsp_valid` lasts exactly one cycle, and the events appear only in that cycle. The memory port never reads and writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is 1 |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2/3 longword |
| req_console | input | 1 | Translate only, silent on errors |
| req_addr | input | 22 | Peripheral-bus byte address |
| req_wdata | input | 32 | Write data, right-justified |
| map_base | input | 30 | Table base byte address (bits 14:0 ignored) |
| mem_rd_en | output | 1 | Memory read strobe, data returns next cycle |
| mem_wr_en | output | 1 | Memory longword write strobe |
| mem_addr | output | 30 | Memory byte address, longword aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after mem_rd_en |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_err | output | 1 | Translation failed |
| rsp_mcheck | output | 1 | Machine check for a failed read |
| rsp_rdata | output | 32 | Read longword |
| rsp_paddr | output | 30 | Translated physical address |
| merr_evt | output | 1 | Master error event (invalid entry) |
| merr_page | output | 13 | Bus page of the master error |
| serr_evt | output | 1 | Slave error event (address outside memory) |
| serr_page | output | 20 | Physical page of the slave error |

## Verification
The bench works on a 64 KB memory whose upper half holds a full 8192-entry table. Every entry is a mix of valid, invalid and out-of-range pages, with junk in bits 30:20. Every page is read once. This catches a design that mixes up master and slave errors, reports the wrong page, fails to mask bits 30:20, or raises a machine check on writes. A run of byte, word and longword writes is read back through aliased pages, and the whole data region is compared at the end. A lane shifted by one byte, or a write that is not blocked after a failure, shows up there. Console sweeps, a table base with junk low bits, and a base placed past memory cover three further faults: a console mode that still reports errors or range-checks, a base whose low bits leak into the entry address, and an entry-address check that is skipped.

// File: rtl/busmap_pkg.sv
// Package: shared encodings for the bus-to-memory page map translator.
// Assumes: size codes are driven by the requester exactly as listed below.
package busmap_pkg;

    // Controller states, one request in flight at a time.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOOKUP = 3'd1,
        ST_CHECK  = 3'd2,
        ST_ACCESS = 3'd3,
        ST_RESP   = 3'd4
    } xl_state_t;

    // Access size codes; any code with bit 1 set is a longword.
    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_WORD = 2'b01;

endpackage

// File: rtl/busmap_addr_calc.sv
// Module: busmap_addr_calc
// Forms the table entry address from the bus page and the table base,
// decodes a fetched entry into a physical address, and range-checks both
// addresses against the installed memory size.
// Assumes: the table base is aligned to the table window; its low bits are
// dropped. Purely combinational.
module busmap_addr_calc #(
    parameter int              BUS_AW     = 22,
    parameter int              PAGE_SHIFT = 9,
    parameter int              PA_W       = 30,
    parameter int              PPN_W      = 20,
    parameter int              DATA_W     = 32,
    parameter longint unsigned MEM_BYTES  = 64'h0100_0000
) (
    input  logic [BUS_AW-1:0]            bus_addr,
    input  logic [PA_W-1:0]              map_base,
    input  logic [DATA_W-1:0]            entry,
    output logic [BUS_AW-PAGE_SHIFT-1:0] bus_page,
    output logic [PA_W-1:0]              entry_addr,
    output logic                         entry_in_mem,
    output logic                         entry_valid,
    output logic [PPN_W-1:0]             entry_ppn,
    output logic [PA_W-1:0]              phys_addr,
    output logic                         phys_in_mem
);
    localparam int              PG_W     = BUS_AW - PAGE_SHIFT;
    localparam int              LANE_W   = $clog2(DATA_W / 8);
    localparam int              WIN_BITS = PG_W + LANE_W;
    localparam logic [PA_W:0]   MEM_LIM  = MEM_BYTES[PA_W:0];

    // Entry address: aligned base plus page scaled to one longword per entry.
    always_comb begin
        bus_page     = bus_addr[BUS_AW-1:PAGE_SHIFT];
        entry_addr   = {map_base[PA_W-1:WIN_BITS], bus_page, {LANE_W{1'b0}}};
        entry_in_mem = ({1'b0, entry_addr} < MEM_LIM);
    end

    // Entry decode: valid flag in the top bit, page frame in the low field.
    always_comb begin
        entry_valid = entry[DATA_W-1];
        entry_ppn   = entry[PPN_W-1:0];
        phys_addr   = PA_W'({entry_ppn, bus_addr[PAGE_SHIFT-1:0]});
        phys_in_mem = ({1'b0, phys_addr} < MEM_LIM);
    end

endmodule

// File: rtl/busmap_lane_merge.sv
// Module: busmap_lane_merge
// Merges right-justified byte or word write data into an old longword at
// the lane chosen by the low address bits; a longword passes straight through.
// Assumes: word accesses use only the upper lane-select bit. Combinational.
module busmap_lane_merge #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]                 old_word,
    input  logic [DATA_W-1:0]                 new_data,
    input  logic [1:0]                        size,
    input  logic [$clog2(DATA_W/8)-1:0]       lane,
    output logic [DATA_W-1:0]                 merged
);
    import busmap_pkg::*;

    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);

    logic [LANES-1:0] byte_en;
    logic [DATA_W-1:0] shifted;

    // Position the write data at its lane.
    always_comb begin
        if (size == SZ_BYTE)
            shifted = new_data << (lane * 8);
        else if (size == SZ_WORD)
            shifted = new_data << ({lane[LANE_W-1:1], 1'b0} * 8);
        else
            shifted = new_data;
    end

    // Per-lane enable and select between new and old bytes.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [LANE_W-1:0] IDX = LANE_W'(i);
        always_comb begin
            if (size == SZ_BYTE)
                byte_en[i] = (lane == IDX);
            else if (size == SZ_WORD)
                byte_en[i] = (lane[LANE_W-1:1] == IDX[LANE_W-1:1]);
            else
                byte_en[i] = 1'b1;
            merged[i*8 +: 8] = byte_en[i] ? shifted[i*8 +: 8] : old_word[i*8 +: 8];
        end
    end

endmodule

// File: rtl/busmap_xlate.sv
// Module: busmap_xlate (top)
// Translates a peripheral-bus address through a page table held in main
// memory, then performs the read or merged write on the translated location.
// Reports failures as master errors (invalid entry) or slave errors (address
// outside installed memory); console requests translate silently.
// Assumes: memory read data arrives one cycle after mem_rd_en; map_base is
// stable while a request is in flight; one request at a time.
module busmap_xlate #(
    parameter int              BUS_AW     = 22,
    parameter int              PAGE_SHIFT = 9,
    parameter int              PA_W       = 30,
    parameter int              PPN_W      = 20,
    parameter int              DATA_W     = 32,
    parameter longint unsigned MEM_BYTES  = 64'h0100_0000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic                         req_write,
    input  logic [1:0]                   req_size,
    input  logic                         req_console,
    input  logic [BUS_AW-1:0]            req_addr,
    input  logic [DATA_W-1:0]            req_wdata,
    input  logic [PA_W-1:0]              map_base,
    output logic                         mem_rd_en,
    output logic                         mem_wr_en,
    output logic [PA_W-1:0]              mem_addr,
    output logic [DATA_W-1:0]            mem_wdata,
    input  logic [DATA_W-1:0]            mem_rdata,
    output logic                         rsp_valid,
    output logic                         rsp_err,
    output logic                         rsp_mcheck,
    output logic [DATA_W-1:0]            rsp_rdata,
    output logic [PA_W-1:0]              rsp_paddr,
    output logic                         merr_evt,
    output logic [BUS_AW-PAGE_SHIFT-1:0] merr_page,
    output logic                         serr_evt,
    output logic [PPN_W-1:0]             serr_page
);
    import busmap_pkg::*;

    localparam int            PG_W    = BUS_AW - PAGE_SHIFT;
    localparam int            LANE_W  = $clog2(DATA_W / 8);
    localparam logic [PA_W:0] MEM_LIM = MEM_BYTES[PA_W:0];

    xl_state_t           st;
    logic                wr_q, con_q, err_q, merr_q, serr_q;
    logic [1:0]          size_q;
    logic [BUS_AW-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q, rdata_q;
    logic [PA_W-1:0]     paddr_q;
    logic [PG_W-1:0]     mpage_q;
    logic [PPN_W-1:0]    spage_q;

    logic [PG_W-1:0]     bus_page;
    logic [PA_W-1:0]     entry_addr, phys_addr;
    logic                entry_in_mem, entry_valid, phys_in_mem;
    logic [PPN_W-1:0]    entry_ppn;
    logic [DATA_W-1:0]   merged;
    logic                is_long;

    busmap_addr_calc #(
        .BUS_AW(BUS_AW), .PAGE_SHIFT(PAGE_SHIFT), .PA_W(PA_W),
        .PPN_W(PPN_W), .DATA_W(DATA_W), .MEM_BYTES(MEM_BYTES)
    ) u_calc (
        .bus_addr     (addr_q),
        .map_base     (map_base),
        .entry        (mem_rdata),
        .bus_page     (bus_page),
        .entry_addr   (entry_addr),
        .entry_in_mem (entry_in_mem),
        .entry_valid  (entry_valid),
        .entry_ppn    (entry_ppn),
        .phys_addr    (phys_addr),
        .phys_in_mem  (phys_in_mem)
    );

    busmap_lane_merge #(.DATA_W(DATA_W)) u_merge (
        .old_word (mem_rdata),
        .new_data (wdata_q),
        .size     (size_q),
        .lane     (addr_q[LANE_W-1:0]),
        .merged   (merged)
    );

    assign is_long = size_q[1];

    // Memory port: entry fetch, target read, or target write per state.
    always_comb begin
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (st)
            ST_LOOKUP: begin
                if (entry_in_mem) begin
                    mem_rd_en = 1'b1;
                    mem_addr  = entry_addr;
                end
            end
            ST_CHECK: begin
                if (entry_valid && !con_q && phys_in_mem) begin
                    mem_addr = {phys_addr[PA_W-1:LANE_W], {LANE_W{1'b0}}};
                    if (wr_q && is_long) begin
                        mem_wr_en = 1'b1;
                        mem_wdata = wdata_q;
                    end else begin
                        mem_rd_en = 1'b1;
                    end
                end
            end
            ST_ACCESS: begin
                mem_addr = {paddr_q[PA_W-1:LANE_W], {LANE_W{1'b0}}};
                if (wr_q) begin
                    mem_wr_en = 1'b1;
                    mem_wdata = merged;
                end
            end
            default: ;
        endcase
    end

    // Controller: sequences lookup, check, access and response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            wr_q    <= 1'b0;
            con_q   <= 1'b0;
            err_q   <= 1'b0;
            merr_q  <= 1'b0;
            serr_q  <= 1'b0;
            size_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            paddr_q <= '0;
            mpage_q <= '0;
            spage_q <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        wr_q    <= req_write;
                        con_q   <= req_console;
                        size_q  <= req_size;
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        err_q   <= 1'b0;
                        merr_q  <= 1'b0;
                        serr_q  <= 1'b0;
                        rdata_q <= '0;
                        paddr_q <= '0;
                        mpage_q <= '0;
                        spage_q <= '0;
                        st      <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (entry_in_mem) begin
                        st <= ST_CHECK;
                    end else begin
                        err_q   <= 1'b1;
                        serr_q  <= !con_q;
                        spage_q <= '0;
                        st      <= ST_RESP;
                    end
                end
                ST_CHECK: begin
                    if (!entry_valid) begin
                        err_q   <= 1'b1;
                        merr_q  <= !con_q;
                        mpage_q <= bus_page;
                        st      <= ST_RESP;
                    end else if (con_q) begin
                        paddr_q <= phys_addr;
                        st      <= ST_RESP;
                    end else if (!phys_in_mem) begin
                        err_q   <= 1'b1;
                        serr_q  <= 1'b1;
                        spage_q <= entry_ppn;
                        st      <= ST_RESP;
                    end else begin
                        paddr_q <= phys_addr;
                        st      <= (wr_q && is_long) ? ST_RESP : ST_ACCESS;
                    end
                end
                ST_ACCESS: begin
                    if (!wr_q)
                        rdata_q <= mem_rdata;
                    st <= ST_RESP;
                end
                default: begin
                    st <= ST_IDLE;
                end
            endcase
        end
    end

    // Response and event outputs, live only in the response cycle.
    always_comb begin
        req_ready  = (st == ST_IDLE);
        rsp_valid  = (st == ST_RESP);
        rsp_err    = rsp_valid && err_q;
        rsp_mcheck = rsp_valid && err_q && !wr_q && !con_q;
        rsp_rdata  = rdata_q;
        rsp_paddr  = paddr_q;
        merr_evt   = rsp_valid && merr_q;
        merr_page  = mpage_q;
        serr_evt   = rsp_valid && serr_q;
        serr_page  = spage_q;
    end

    AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en)); // R10
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R10
    AST_WR_IN_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ({1'b0, mem_addr} < MEM_LIM)); // R5
    AST_EVT_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (merr_evt || serr_evt) |-> (rsp_valid && rsp_err)); // R4
    AST_CON_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && con_q) |-> !(merr_evt || serr_evt || rsp_mcheck)); // R9
    AST_MCHK_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_mcheck |-> (rsp_err && !wr_q)); // R8
    AST_NO_WR_CONSOLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && con_q) |-> !mem_wr_en); // R9

endmodule

// File: tb/busmap_xlate_bench.sv
`timescale 1ns/1ps
module busmap_xlate_bench;

    localparam longint unsigned MEM_BYTES = 64'd65536;
    localparam int WORDS = 16384;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        req_console = 1'b0;
    logic [21:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [29:0] map_base = 30'h8000;
    logic        mem_rd_en, mem_wr_en;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid, rsp_err, rsp_mcheck;
    logic [31:0] rsp_rdata;
    logic [29:0] rsp_paddr;
    logic        merr_evt, serr_evt;
    logic [12:0] merr_page;
    logic [19:0] serr_page;

    busmap_xlate #(.MEM_BYTES(MEM_BYTES)) u_busmap_xlate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_size(req_size), .req_console(req_console),
        .req_addr(req_addr), .req_wdata(req_wdata), .map_base(map_base),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_mcheck(rsp_mcheck), .rsp_rdata(rsp_rdata),
        .rsp_paddr(rsp_paddr), .merr_evt(merr_evt), .merr_page(merr_page),
        .serr_evt(serr_evt), .serr_page(serr_page)
    );

    always #2 clk = ~clk;

    logic [31:0] mem  [WORDS];
    logic [31:0] gold [WORDS];
    int wr_count = 0;
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Memory model: one-cycle read latency, longword writes.
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr[15:2]];
        if (mem_wr_en) begin
            mem[mem_addr[15:2]] = mem_wdata;
            wr_count = wr_count + 1;
        end
    end

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog R10 act=%0d exp=<190000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] entry_of(input int p);
        logic [19:0] ppn;
        logic        vld;
        vld = (p % 5) != 3;
        ppn = ((p % 7) == 6) ? 20'(200 + (p % 50)) : 20'(p % 64);
        return {vld, 11'(p), ppn};
    endfunction

    // Request one operation and compare every response field with the model.
    task automatic do_op(input logic wr, input logic [1:0] sz, input logic con,
                         input logic [21:0] a, input logic [31:0] wd);
        logic [29:0] ea, pa;
        logic [31:0] e, oldw, msk;
        int sh, wc0, n;
        logic x_err, x_mck, x_merr, x_serr, ok;
        logic [12:0] x_mp;
        logic [19:0] x_sp;
        string tag;
        x_err = 0; x_mck = 0; x_merr = 0; x_serr = 0; ok = 0;
        x_mp = '0; x_sp = '0; pa = '0; tag = "R6";
        ea = {map_base[29:15], a[21:9], 2'b00};
        if (ea >= 30'(MEM_BYTES)) begin
            tag = "R3"; x_err = 1; x_serr = !con; x_sp = 0;
        end else begin
            e = gold[ea[15:2]];
            if (!e[31]) begin
                tag = "R4"; x_err = 1; x_merr = !con; x_mp = a[21:9];
            end else begin
                pa = {1'b0, e[19:0], a[8:0]};
                if (con) begin
                    tag = "R9";
                end else if (pa >= 30'(MEM_BYTES)) begin
                    tag = "R5"; x_err = 1; x_serr = 1; x_sp = e[19:0];
                end else begin
                    ok = 1;
                    tag = wr ? "R7" : "R6";
                end
            end
        end
        if (con) tag = "R9";
        x_mck = x_err && !wr && !con;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_size = sz; req_console = con;
        req_addr = a; req_wdata = wd;
        wc0 = wr_count;
        @(negedge clk);
        req_valid = 0;
        chk("R10 busy", {31'b0, req_ready}, 32'd0);
        n = 0;
        while (!rsp_valid && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk("R10 response seen", {31'b0, rsp_valid}, 32'd1);
        chk({tag, " err"}, {31'b0, rsp_err}, {31'b0, x_err});
        chk("R8 mcheck", {31'b0, rsp_mcheck}, {31'b0, x_mck});
        chk({tag, " merr_evt"}, {31'b0, merr_evt}, {31'b0, x_merr});
        chk({tag, " serr_evt"}, {31'b0, serr_evt}, {31'b0, x_serr});
        if (x_merr) chk("R4 merr_page", 32'(merr_page), 32'(x_mp));
        if (x_serr) chk({tag, " serr_page"}, 32'(serr_page), 32'(x_sp));
        if (!x_err && (ok || con)) chk({tag, " paddr"}, 32'(rsp_paddr), 32'(pa));
        if (ok && !wr) chk("R6 rdata", rsp_rdata, gold[pa[15:2]]);
        if (ok && wr) begin
            oldw = gold[pa[15:2]];
            if (sz == 2'd0) begin
                sh = 8 * int'(a[1:0]); msk = 32'hFF;
                gold[pa[15:2]] = (oldw & ~(msk << sh)) | ((wd & msk) << sh);
            end else if (sz == 2'd1) begin
                sh = 16 * int'(a[1]); msk = 32'hFFFF;
                gold[pa[15:2]] = (oldw & ~(msk << sh)) | ((wd & msk) << sh);
            end else begin
                gold[pa[15:2]] = wd;
            end
        end
        @(negedge clk);
        chk("R10 pulse", {31'b0, rsp_valid}, 32'd0);
        chk((ok && wr) ? "R7 write count" : "R8 write count",
            32'(wr_count - wc0), (ok && wr) ? 32'd1 : 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 8192; i++) begin
            mem[i]  = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
            gold[i] = mem[i];
        end
        for (int p = 0; p < 8192; p++) begin
            mem[8192 + p]  = entry_of(p);
            gold[8192 + p] = entry_of(p);
        end
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", {31'b0, req_ready}, 32'd1);
        chk("R1 rsp in reset", {31'b0, rsp_valid}, 32'd0);
        chk("R1 mem idle in reset", {30'b0, mem_rd_en, mem_wr_en}, 32'd0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 ready", {31'b0, req_ready}, 32'd1);
        chk("R1 flags", {26'b0, rsp_valid, rsp_err, rsp_mcheck, merr_evt, serr_evt, mem_rd_en}, 32'd0);

        // R6 R4 R5: read every page once at a varying offset.
        for (int p = 0; p < 8192; p++)
            do_op(1'b0, 2'd2, 1'b0, {13'(p), 9'((p * 37) % 512)}, 32'd0);

        // R7: byte, word and longword writes, then read back.
        for (int k = 0; k < 600; k++) begin
            logic [21:0] a;
            a = {13'((k * 11) % 8192), 9'((k * 13) % 512)};
            do_op(1'b1, 2'(k % 4), 1'b0, a, (k * 32'h01010101) ^ 32'hC3A5_96E1);
            do_op(1'b0, 2'd2, 1'b0, a, 32'd0);
        end

        // R9: console translation over a range of pages, reads and writes.
        for (int p = 0; p < 400; p++)
            do_op(1'(p % 2), 2'(p % 3), 1'b1, {13'(p * 3), 9'(p)}, 32'hFFFF_FFFF);

        // R2: low base bits ignored.
        map_base = 30'h8000 | 30'h5A5A;
        for (int p = 0; p < 64; p++)
            do_op(1'b0, 2'd2, 1'b0, {13'(p * 97), 9'(p * 5)}, 32'd0);

        // R3: table base past memory; reads, writes and console.
        map_base = 30'h10000;
        do_op(1'b0, 2'd2, 1'b0, 22'h01_2345, 32'd0);
        do_op(1'b1, 2'd0, 1'b0, 22'h00_0203, 32'hAB);
        do_op(1'b0, 2'd1, 1'b1, 22'h3F_FFFF, 32'd0);
        map_base = 30'h8000;

        // R8: memory content matches the model after all traffic.
        for (int i = 0; i < 8192; i++)
            chk("R8 memory", mem[i], gold[i]);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule